// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers configuration-space accesses for a simple serial controller that sits behind a type-0 PCI header. Software reaches it through a flat register port. A write carries a dword address, four byte enables and 32 bits of data. A read carries a dword address, and its 32-bit result comes back one cycle later. The write side and the read side are separate, so a read and a write can be issued in the same cycle.

The identity, command/status, class and interrupt-pin fields are held at fixed values. The block emulates one or two 8-byte I/O base address registers, and a parameter sets how many ports there are. The three BAR slots above them are permanently zero. Only the interrupt line byte accepts ordinary writes. Every other field ignores writes and returns its reset value. Addresses beyond the 64-dword window read as zero.

Top module: `pci_cfg_responder`

## Requirements
- R1: Dword 0 (byte offset 0x00) and dword 11 (byte offset 0x2C) always read 0x32534348. Writes to them have no effect.
- R2: Dword 1 reads 0x02000001. The low half is the command word 0x0001 (I/O decode only). The high half is the status word 0x0200 (no capability list). Writes never change it.
- R3: Dword 2 reads 0x07000210. Byte 0 is the revision 0x10, byte 1 is the programming interface 0x02, byte 2 is the subclass 0x00 and byte 3 is the base class 0x07. It is read-only.
- R4: The first BAR (dword 4) reads 0x00000001 after reset. A write with all four byte enables set and data 0xFFFFFFFF makes it read 0xFFFFFFF9: the 8-byte size mask with the I/O marker kept.
- R5: Any other write to an implemented BAR replaces the bytes whose enables are set with the written bytes. Bits 1:0 still read 01.
- R6: The second BAR (dword 5) behaves as in R4 and R5 when NUM_PORTS is 2. When NUM_PORTS is 1 it reads zero, and writes to it leave it at zero.
- R7: Dwords 6, 7 and 8 read zero whatever is written to them.
- R8: In dword 15, byte 0 is the interrupt line. It resets to 0x00 and is written when byte enable 0 is set. Byte 1 is the interrupt pin, which reads 0x01 and cannot be written. Bytes 2 and 3 read zero.
- R9: Dword 13 (capability pointer at byte 0x34) reads zero.
- R10: Any other dword inside the window reads zero and ignores writes. Any dword address of 64 or above reads zero.
- R11: rd_valid is high exactly one cycle after rd_en. rd_data then carries the addressed dword and holds until the next read. Both are zero after reset.
- R12: Bytes whose enable is clear are never altered. When a read and a write address the same dword in one cycle, the read returns the value from before the write. A read issued in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Dword address of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Dword address of the read |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | 32 | Read result, held until the next read |

## Verification
A read and a write can land on the same dword in the same cycle, either on a BAR or on the interrupt line. In that cycle the read must return the value from before the write, and the write must still take effect. The bench provokes this with directed same-cycle pairs on both writable dwords, including a sizing write. It also runs a long random phase whose address pool is small, so such collisions happen often. A behavioural model samples the read value before it applies the write, so any forwarding or lost update shows up as a mismatch on the next cycle's read data. A second instance built with one port runs on the same stimulus and checks that the second BAR never leaves zero.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
  // dword slots of the header that carry behaviour
  localparam int DW_W       = 6;
  localparam int BAR_SLOTS  = 5;
  localparam logic [DW_W-1:0] DW_IDENT  = 6'd0;
  localparam logic [DW_W-1:0] DW_CMDSTS = 6'd1;
  localparam logic [DW_W-1:0] DW_CLASS  = 6'd2;
  localparam logic [DW_W-1:0] DW_BAR0   = 6'd4;
  localparam logic [DW_W-1:0] DW_SUBSYS = 6'd11;
  localparam logic [DW_W-1:0] DW_IRQ    = 6'd15;
  localparam logic [1:0]      IO_MARK   = 2'b01;
endpackage

// File: rtl/cfgsp_bar.sv
module cfgsp_bar
  import cfgsp_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] bar_q
);
  localparam logic [31:0] SIZE_MASK = ~(32'(WIN_BYTES)) + 32'd1;

  logic [31:2] addr_q;
  logic [31:2] addr_d;
  logic        sizing;

  // next-state: byte merge, sizing pattern overrides
  always_comb begin
    sizing = (wr_be == 4'hF) && (wr_data == 32'hFFFF_FFFF);
    addr_d = addr_q;
    if (wr_be[0]) addr_d[7:2] = wr_data[7:2];
    for (int b = 1; b < 4; b++) begin
      if (wr_be[b]) addr_d[8*b +: 8] = wr_data[8*b +: 8];
    end
    if (sizing) addr_d = SIZE_MASK[31:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (wr_hit) addr_q <= addr_d;
  end

  assign bar_q = {addr_q, IO_MARK};

  p_bar_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_be == 4'hF && wr_data == 32'hFFFF_FFFF)
      |=> (bar_q == {SIZE_MASK[31:2], IO_MARK}));

  p_bar_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bar_q));

  p_bar_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_be == 4'h0) |=> $stable(bar_q));
endmodule

// File: rtl/cfgsp_irq_line.sv
module cfgsp_irq_line #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [LINE_W-1:0] wr_byte,
  output logic [LINE_W-1:0] line_q
);
  logic [LINE_W-1:0] line_d;

  always_comb line_d = wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      line_q <= '0;
    else if (wr_hit) line_q <= line_d;
  end

  p_line_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(line_q));

  p_line_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (line_q == $past(wr_byte)));
endmodule

// File: rtl/cfgsp_hdr_rom.sv
module cfgsp_hdr_rom
  import cfgsp_pkg::*;
#(
  parameter logic [31:0] IDENT_WORD  = 32'h3253_4348,
  parameter logic [31:0] SUBSYS_WORD = 32'h3253_4348,
  parameter logic [15:0] CMD_WORD    = 16'h0001,
  parameter logic [15:0] STS_WORD    = 16'h0200,
  parameter logic [31:0] CLASS_WORD  = 32'h0700_0210,
  parameter logic [7:0]  PIN_BYTE    = 8'h01
) (
  input  logic [DW_W-1:0] dw,
  input  logic [31:0]     bars [BAR_SLOTS],
  input  logic [7:0]      irq_line,
  output logic [31:0]     rdata
);
  always_comb begin
    rdata = '0;
    unique case (dw)
      DW_IDENT:  rdata = IDENT_WORD;
      DW_SUBSYS: rdata = SUBSYS_WORD;
      DW_CMDSTS: rdata = {STS_WORD, CMD_WORD};
      DW_CLASS:  rdata = CLASS_WORD;
      DW_IRQ:    rdata = {16'h0000, PIN_BYTE, irq_line};
      default:   rdata = '0;
    endcase
    for (int i = 0; i < BAR_SLOTS; i++) begin
      if (dw == DW_W'(int'(DW_BAR0) + i)) rdata = bars[i];
    end
  end
endmodule

// File: rtl/pci_cfg_responder.sv
module pci_cfg_responder
  import cfgsp_pkg::*;
#(
  parameter int          NUM_PORTS   = 2,
  parameter int          ADDR_W      = 10,
  parameter int unsigned IO_WIN      = 8,
  parameter logic [31:0] IDENT_WORD  = 32'h3253_4348,
  parameter logic [31:0] SUBSYS_WORD = 32'h3253_4348,
  parameter logic [15:0] CMD_WORD    = 16'h0001,
  parameter logic [15:0] STS_WORD    = 16'h0200,
  parameter logic [31:0] CLASS_WORD  = 32'h0700_0210,
  parameter logic [7:0]  PIN_BYTE    = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  localparam int HI_W = ADDR_W - DW_W;

  logic            wr_in_win, rd_in_win;
  logic [DW_W-1:0] wr_dw, rd_dw;
  logic [31:0]     bars [BAR_SLOTS];
  logic [7:0]      irq_line;
  logic            irq_hit;
  logic [31:0]     rom_word;
  logic            rd_valid_d, rd_valid_q;
  logic [31:0]     rd_data_d, rd_data_q;

  assign wr_in_win = (wr_addr[ADDR_W-1:DW_W] == HI_W'(0));
  assign rd_in_win = (rd_addr[ADDR_W-1:DW_W] == HI_W'(0));
  assign wr_dw     = wr_addr[DW_W-1:0];
  assign rd_dw     = rd_addr[DW_W-1:0];

  // BAR slots: implemented ones per port, the rest tied to zero
  for (genvar g = 0; g < BAR_SLOTS; g++) begin : g_bar
    if (g < NUM_PORTS) begin : g_live
      logic hit;
      assign hit = wr_en && wr_in_win && (wr_dw == DW_W'(int'(DW_BAR0) + g));
      cfgsp_bar #(.WIN_BYTES(IO_WIN)) u_bar (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .bar_q   (bars[g])
      );
    end else begin : g_tied
      assign bars[g] = '0;
    end
  end

  assign irq_hit = wr_en && wr_in_win && (wr_dw == DW_IRQ) && wr_be[0];

  cfgsp_irq_line #(.LINE_W(8)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (irq_hit),
    .wr_byte (wr_data[7:0]),
    .line_q  (irq_line)
  );

  cfgsp_hdr_rom #(
    .IDENT_WORD  (IDENT_WORD),
    .SUBSYS_WORD (SUBSYS_WORD),
    .CMD_WORD    (CMD_WORD),
    .STS_WORD    (STS_WORD),
    .CLASS_WORD  (CLASS_WORD),
    .PIN_BYTE    (PIN_BYTE)
  ) u_rom (
    .dw       (rd_dw),
    .bars     (bars),
    .irq_line (irq_line),
    .rdata    (rom_word)
  );

  // read path next-state
  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_in_win ? rom_word : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_d;
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  p_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(0)) |=> (rd_data == IDENT_WORD));

  p_cmdsts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(1)) |=> (rd_data == {STS_WORD, CMD_WORD}));

  p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[ADDR_W-1:DW_W] != HI_W'(0)) |=> (rd_data == 32'h0));
endmodule

// File: tb/pci_cfg_responder_tb.sv
`timescale 1ns/1ps
module pci_cfg_responder_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_be = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid, rd_valid_s;
  logic [31:0]   rd_data, rd_data_s;

  always #2.5 clk = ~clk;

  pci_cfg_responder #(.NUM_PORTS(2), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data));

  pci_cfg_responder #(.NUM_PORTS(1), .ADDR_W(AW)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid_s), .rd_data(rd_data_s));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [31:0] m_bar0, m_bar1;
  logic [7:0]  m_line;
  logic        exp_valid;
  logic [31:0] exp_d, exp_ds;
  string       exp_tag = "R11";

  function automatic logic [31:0] model_read(int a, bit dual);
    if (a >= 64) return 32'h0;
    case (a)
      0, 11:   return 32'h3253_4348;
      1:       return 32'h0200_0001;
      2:       return 32'h0700_0210;
      4:       return m_bar0;
      5:       return dual ? m_bar1 : 32'h0;
      15:      return {16'h0000, 8'h01, m_line};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (a >= 64) return "R10";
    case (a)
      0, 11:   return "R1";
      1:       return "R2";
      2:       return "R3";
      4:       return "R4 R5 R12";
      5:       return "R6";
      6, 7, 8: return "R7";
      13:      return "R9";
      15:      return "R8 R12";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] bar_write(logic [31:0] old, logic [3:0] be, logic [31:0] d);
    logic [31:0] r;
    if (be == 4'hF && d == 32'hFFFF_FFFF) return 32'hFFFF_FFF9;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    r[1:0] = 2'b01;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bar0 = 32'h1; m_bar1 = 32'h1; m_line = 8'h0;
      exp_valid = 1'b0; exp_d = 32'h0; exp_ds = 32'h0;
    end else begin
      exp_valid = rd_en;
      if (rd_en) begin
        exp_d   = model_read(int'(rd_addr), 1'b1);
        exp_ds  = model_read(int'(rd_addr), 1'b0);
        exp_tag = tag_of(int'(rd_addr));
      end
      if (wr_en) begin
        if (wr_addr == AW'(4)) m_bar0 = bar_write(m_bar0, wr_be, wr_data);
        if (wr_addr == AW'(5)) m_bar1 = bar_write(m_bar1, wr_be, wr_data);
        if (wr_addr == AW'(15) && wr_be[0]) m_line = wr_data[7:0];
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(rd_valid == 1'b0 && rd_data == 32'h0, "R11", "reset dual",
            rd_data, 32'h0);
        chk(rd_valid_s == 1'b0 && rd_data_s == 32'h0, "R11", "reset single",
            rd_data_s, 32'h0);
      end else begin
        chk(rd_valid == exp_valid, "R11", "rd_valid dual",
            32'(rd_valid), 32'(exp_valid));
        chk(rd_valid_s == exp_valid, "R11", "rd_valid single",
            32'(rd_valid_s), 32'(exp_valid));
        chk(rd_data == exp_d, exp_tag, "rd_data dual", rd_data, exp_d);
        chk(rd_data_s == exp_ds, exp_tag, "rd_data single", rd_data_s, exp_ds);
      end
    end
  end

  task automatic cyc(bit we, int wa, logic [3:0] be, logic [31:0] wd, bit re, int ra);
    @(negedge clk); #1;
    wr_en = we; wr_addr = AW'(wa); wr_be = be; wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
  endtask

  task automatic rd(int a);
    cyc(1'b0, 0, 4'h0, 32'h0, 1'b1, a);
  endtask

  task automatic wr(int a, logic [3:0] be, logic [31:0] d);
    cyc(1'b1, a, be, d, 1'b0, 0);
  endtask

  task automatic idle();
    cyc(1'b0, 0, 4'h0, 32'h0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 R2 R3 R9 R10: full scan of the reset image and beyond the window
    for (int a = 0; a < 64; a++) rd(a);
    rd(64); rd(255); rd(1023);
    // read-only fields ignore full writes
    wr(0, 4'hF, 32'hDEAD_BEEF); wr(1, 4'hF, 32'h0000_0000);
    wr(2, 4'hF, 32'hFFFF_FFFF); wr(11, 4'hF, 32'h1234_5678);
    wr(13, 4'hF, 32'hFFFF_FFFF); wr(40, 4'hF, 32'hA5A5_A5A5);
    wr(6, 4'hF, 32'hFFFF_FFFF); wr(7, 4'hF, 32'h0000_1230); wr(8, 4'hF, 32'hFFFF_FFFF);
    rd(0); rd(1); rd(2); rd(11); rd(13); rd(40); rd(6); rd(7); rd(8);
    // R4: sizing on both BARs
    wr(4, 4'hF, 32'hFFFF_FFFF); rd(4);
    wr(5, 4'hF, 32'hFFFF_FFFF); rd(5);
    // R5: address programming, marker bits held
    wr(4, 4'hF, 32'h0000_C0F2); rd(4);
    wr(5, 4'hF, 32'h0000_E010); rd(5);
    wr(4, 4'b0111, 32'hFFFF_FFFF); rd(4);
    wr(4, 4'b0010, 32'h0000_3400); rd(4);
    // R12: zero enables change nothing
    wr(4, 4'h0, 32'h1111_1111); rd(4);
    // R8: interrupt line and pin
    wr(15, 4'b0001, 32'hFFFF_FF0B); rd(15);
    wr(15, 4'b1110, 32'hFFFF_FF77); rd(15);
    wr(15, 4'h0, 32'h0000_0033); rd(15);
    // R12: same-cycle read and write of one dword
    cyc(1'b1, 4, 4'hF, 32'hFFFF_FFFF, 1'b1, 4); rd(4);
    cyc(1'b1, 5, 4'hF, 32'h0000_A000, 1'b1, 5); rd(5);
    cyc(1'b1, 15, 4'b0001, 32'h0000_0042, 1'b1, 15); rd(15);
    idle(); idle();
    // random phase over a small address pool
    for (int n = 0; n < 3000; n++) begin
      int pool [10] = '{0, 1, 2, 4, 5, 6, 13, 15, 20, 70};
      logic [31:0] d;
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom();
      cyc(1'($urandom_range(0, 1)), pool[$urandom_range(0, 9)], 4'($urandom_range(0, 15)), d,
          1'($urandom_range(0, 1)), pool[$urandom_range(0, 9)]);
    end
    idle(); idle(); idle();
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule